// File: doc/BRIEF.md
# Group Bitmap Low-Bit Sorter

This block is the lowest level of a hierarchical sorter. Each incoming item is split into two parts. The high part is a group prefix. The low part is a small value of `LOW_W` bits. For every group the block keeps a presence word of `2^LOW_W` bits, and an arriving item sets the bit whose index is its low value. Storing the low values this way means a group is already in sorted order. To read a group back, the block scans its presence word from bit 0 upwards.

A drain request names one group. From the next cycle the block streams that group's items, one per cycle, in ascending order. Each output item is the group prefix joined with the index of a set bit. A done pulse marks the end of every drain, including the drain of an empty group. Ordering between groups is left to the logic above this block. A synchronous clear empties every group. While a group is being drained, items for that group are held off through a ready signal, so the scan never mixes with new writes.

Top module: `grp_sorter`

## Requirements
- R1: An item of `ITEM_W` bits is split into two fields. The upper `ITEM_W-LOW_W` bits select the group. The lower `LOW_W` bits are the value that is sorted inside that group.
- R2: Accepting an item (`item_valid_i` and `item_ready_o` both high at a clock edge) sets bit `item_i[LOW_W-1:0]` of the selected group's presence word. Bits that are already set stay set until a clear.
- R3: With the default widths (4-bit items, 2 low bits), the item sequence 3,8,1,6,9,13,15,7,11,10,14 leaves these presence words, written with bit 0 as the rightmost bit: group 0 = 4'b1010, group 1 = 4'b1100, group 2 = 4'b1111, group 3 = 4'b1110.
- R4: A drain request is accepted at a clock edge when `drain_req_i` and `drain_ready_o` are both high. From the cycle after acceptance, the block outputs one item per cycle with `out_valid_o` high. The items come in strictly ascending order, and each one equals `{group, bit index}`.
- R5: `out_last_o` and `drain_done_o` are both high together with the highest set bit of the group, and never with any other item.
- R6: Draining a group whose presence word is empty produces no valid output. Instead, `drain_done_o` pulses for one cycle in the cycle after acceptance.
- R7: When items with the same value arrive more than once, that value is output only once.
- R8: `clear_i` empties every group at the next edge. If an item arrives in the same cycle as the clear, the clear takes priority.
- R9: `item_ready_o` is low for an item of the group being drained. This applies from the cycle the drain request is accepted until the end of that drain. An item presented while `item_ready_o` is low is not recorded. Items for other groups are accepted during a drain.
- R10: `drain_ready_o` is low from acceptance until the cycle after `drain_done_o`. A request made while it is low is ignored and produces no output.
- R11: After reset, `out_valid_o` and `drain_done_o` are low, both ready outputs are high, and every group is empty.
- R12: A drain does not change the presence word, so draining the same group again gives the same stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Empty all groups |
| item_valid_i | input | 1 | Item present |
| item_i | input | ITEM_W | Item: group prefix and low value |
| item_ready_o | output | 1 | Item can be accepted |
| drain_req_i | input | 1 | Drain request |
| drain_grp_i | input | ITEM_W-LOW_W | Group to drain |
| drain_ready_o | output | 1 | Drain request can be accepted |
| out_valid_o | output | 1 | Output item valid |
| out_item_o | output | ITEM_W | Sorted output item |
| out_last_o | output | 1 | Highest item of the group |
| drain_done_o | output | 1 | Drain finished in this cycle |

## Verification
A wrong presence bit, such as a missing, extra or stale bit, stays hidden until its group is drained. Once drained, it shows up as a missing, extra or out-of-order item, or as `out_last_o` falling on the wrong item. The error appears within `2^LOW_W` cycles of the request. A broken scan register shows up as repeated or skipped indices, or as a drain that never raises `drain_done_o`. A hold-off fault shows up one drain later, when a blocked item appears in the stream anyway. For this reason every write and every clear scenario ends with a drain of the affected groups.

// File: rtl/grp_sorter_pkg.sv
package grp_sorter_pkg;
  typedef enum logic {
    DR_IDLE = 1'b0,
    DR_SCAN = 1'b1
  } drain_state_e;
endpackage

// File: rtl/grp_mask_bank.sv
module grp_mask_bank #(
  parameter int GRP_N  = 4,
  parameter int GRP_W  = 2,
  parameter int LOW_W  = 2,
  parameter int MASK_W = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clear_i,
  input  logic                      wr_en_i,
  input  logic [GRP_W-1:0]          wr_grp_i,
  input  logic [LOW_W-1:0]          wr_low_i,
  input  logic [GRP_W-1:0]          rd_grp_i,
  output logic [MASK_W-1:0]         rd_mask_o,
  output logic [GRP_N*MASK_W-1:0]   masks_o
);
  logic [MASK_W-1:0] mask_q [GRP_N];

  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      mask_q[g] <= '0;
      else if (clear_i)                                 mask_q[g] <= '0;
      else if (wr_en_i && (wr_grp_i == GRP_W'(g)))      mask_q[g] <= mask_q[g] | (MASK_W'(1) << wr_low_i);
    end
    assign masks_o[g*MASK_W +: MASK_W] = mask_q[g];
  end

  assign rd_mask_o = mask_q[rd_grp_i];
endmodule

// File: rtl/grp_lsb_pick.sv
module grp_lsb_pick #(
  parameter int W     = 4,
  parameter int IDX_W = 2
) (
  input  logic [W-1:0]     vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o,
  output logic             single_o
);
  // descending walk so the lowest set bit wins
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o    = |vec_i;
  assign single_o = any_o && ((vec_i & (vec_i - W'(1))) == '0);
endmodule

// File: rtl/grp_drain_ctrl.sv
module grp_drain_ctrl
  import grp_sorter_pkg::*;
#(
  parameter int GRP_W  = 2,
  parameter int LOW_W  = 2,
  parameter int MASK_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [GRP_W-1:0]  grp_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic              ready_o,
  output logic              busy_o,
  output logic [GRP_W-1:0]  grp_o,
  output logic              valid_o,
  output logic [LOW_W-1:0]  low_o,
  output logic              last_o,
  output logic              done_o
);
  drain_state_e      state_q;
  logic [MASK_W-1:0] scan_q;
  logic [GRP_W-1:0]  grp_q;
  logic              any, single;
  logic [LOW_W-1:0]  idx;
  logic              accept;

  grp_lsb_pick #(.W(MASK_W), .IDX_W(LOW_W)) u_pick (
    .vec_i   (scan_q),
    .idx_o   (idx),
    .any_o   (any),
    .single_o(single)
  );

  assign ready_o = (state_q == DR_IDLE);
  assign busy_o  = (state_q == DR_SCAN);
  assign accept  = req_i && ready_o;
  assign valid_o = busy_o && any;
  assign last_o  = busy_o && single;
  assign done_o  = busy_o && (single || !any);
  assign low_o   = idx;
  assign grp_o   = grp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DR_IDLE;
      scan_q  <= '0;
      grp_q   <= '0;
    end else if (accept) begin
      state_q <= DR_SCAN;
      scan_q  <= mask_i;
      grp_q   <= grp_i;
    end else if (busy_o) begin
      if (done_o) begin
        state_q <= DR_IDLE;
        scan_q  <= '0;
      end else begin
        scan_q  <= scan_q & ~(MASK_W'(1) << idx);
      end
    end
  end
endmodule

// File: rtl/grp_sorter.sv
module grp_sorter
  import grp_sorter_pkg::*;
#(
  parameter int ITEM_W = 4,
  parameter int LOW_W  = 2,
  localparam int GRP_W  = ITEM_W - LOW_W,
  localparam int GRP_N  = 1 << GRP_W,
  localparam int MASK_W = 1 << LOW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              item_valid_i,
  input  logic [ITEM_W-1:0] item_i,
  output logic              item_ready_o,
  input  logic              drain_req_i,
  input  logic [GRP_W-1:0]  drain_grp_i,
  output logic              drain_ready_o,
  output logic              out_valid_o,
  output logic [ITEM_W-1:0] out_item_o,
  output logic              out_last_o,
  output logic              drain_done_o
);
  logic [GRP_W-1:0]        item_grp;
  logic [LOW_W-1:0]        item_low;
  logic [MASK_W-1:0]       rd_mask;
  logic [GRP_N*MASK_W-1:0] masks_flat;
  logic                    busy;
  logic [GRP_W-1:0]        act_grp;
  logic [LOW_W-1:0]        out_low;
  logic                    hit_active, hit_new;

  assign item_grp = item_i[ITEM_W-1 -: GRP_W];
  assign item_low = item_i[LOW_W-1:0];

  // hold off writes to the group whose word is being scanned
  assign hit_active   = busy && (item_grp == act_grp);
  assign hit_new      = drain_req_i && drain_ready_o && (item_grp == drain_grp_i);
  assign item_ready_o = !(hit_active || hit_new);

  grp_mask_bank #(
    .GRP_N(GRP_N), .GRP_W(GRP_W), .LOW_W(LOW_W), .MASK_W(MASK_W)
  ) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear_i),
    .wr_en_i  (item_valid_i && item_ready_o),
    .wr_grp_i (item_grp),
    .wr_low_i (item_low),
    .rd_grp_i (drain_grp_i),
    .rd_mask_o(rd_mask),
    .masks_o  (masks_flat)
  );

  grp_drain_ctrl #(
    .GRP_W(GRP_W), .LOW_W(LOW_W), .MASK_W(MASK_W)
  ) u_drain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (drain_req_i),
    .grp_i  (drain_grp_i),
    .mask_i (rd_mask),
    .ready_o(drain_ready_o),
    .busy_o (busy),
    .grp_o  (act_grp),
    .valid_o(out_valid_o),
    .low_o  (out_low),
    .last_o (out_last_o),
    .done_o (drain_done_o)
  );

  assign out_item_o = {act_grp, out_low};
endmodule

// File: rtl/grp_sorter_chk.sv
module grp_sorter_chk #(
  parameter int ITEM_W = 4,
  parameter int LOW_W  = 2,
  localparam int GRP_W  = ITEM_W - LOW_W,
  localparam int GRP_N  = 1 << GRP_W,
  localparam int MASK_W = 1 << LOW_W
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    clear_i,
  input logic                    item_valid_i,
  input logic [ITEM_W-1:0]       item_i,
  input logic                    item_ready_o,
  input logic                    drain_req_i,
  input logic                    drain_ready_o,
  input logic                    out_valid_o,
  input logic [ITEM_W-1:0]       out_item_o,
  input logic                    out_last_o,
  input logic                    drain_done_o,
  input logic [GRP_N*MASK_W-1:0] masks_i
);
  AST_LAST_IS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> (out_valid_o && drain_done_o)); // R5

  AST_ASCENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_last_o) |=> (out_valid_o && (out_item_o > $past(out_item_o)))); // R4

  AST_ACCEPT_RESPONDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drain_req_i && drain_ready_o) |=> (out_valid_o || drain_done_o)); // R6

  AST_DONE_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_done_o |=> (drain_ready_o && !out_valid_o)); // R10

  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (masks_i == '0)); // R8

  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && item_valid_i && (item_i[ITEM_W-1 -: GRP_W] == out_item_o[ITEM_W-1 -: GRP_W]))
      |-> !item_ready_o); // R9

  AST_BITS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> (($past(masks_i) & ~masks_i) == '0)); // R2
endmodule

bind grp_sorter grp_sorter_chk #(.ITEM_W(ITEM_W), .LOW_W(LOW_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clear_i      (clear_i),
  .item_valid_i (item_valid_i),
  .item_i       (item_i),
  .item_ready_o (item_ready_o),
  .drain_req_i  (drain_req_i),
  .drain_ready_o(drain_ready_o),
  .out_valid_o  (out_valid_o),
  .out_item_o   (out_item_o),
  .out_last_o   (out_last_o),
  .drain_done_o (drain_done_o),
  .masks_i      (masks_flat)
);

// File: tb/grp_sorter_tb.sv
module grp_sorter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ITEM_W = 4;
  localparam int LOW_W  = 2;
  localparam int GRP_W  = ITEM_W - LOW_W;
  localparam int MASK_W = 1 << LOW_W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic clear_i = 1'b0;
  logic item_valid_i = 1'b0;
  logic [ITEM_W-1:0] item_i = '0;
  logic drain_req_i = 1'b0;
  logic [GRP_W-1:0] drain_grp_i = '0;
  logic item_ready_o, drain_ready_o, out_valid_o, out_last_o, drain_done_o;
  logic [ITEM_W-1:0] out_item_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  grp_sorter #(.ITEM_W(ITEM_W), .LOW_W(LOW_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear_i),
    .item_valid_i(item_valid_i), .item_i(item_i), .item_ready_o(item_ready_o),
    .drain_req_i(drain_req_i), .drain_grp_i(drain_grp_i), .drain_ready_o(drain_ready_o),
    .out_valid_o(out_valid_o), .out_item_o(out_item_o), .out_last_o(out_last_o),
    .drain_done_o(drain_done_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int v);
    @(negedge clk);
    item_valid_i = 1'b1;
    item_i = ITEM_W'(v);
    @(posedge clk);
    #1 item_valid_i = 1'b0;
  endtask

  // drain one group and compare the stream with the expected presence word
  task automatic drain_check(input int g, input logic [MASK_W-1:0] m, input string tag);
    int rem;
    rem = $countones(m);
    @(negedge clk);
    drain_req_i = 1'b1;
    drain_grp_i = GRP_W'(g);
    #1 chk(drain_ready_o, {tag, " R10 drain_ready"}, drain_ready_o, 1);
    @(negedge clk);
    drain_req_i = 1'b0;
    if (rem == 0) begin
      chk(!out_valid_o && drain_done_o, {tag, " R6 empty drain"},
          {out_valid_o, drain_done_o}, 1);
    end else begin
      for (int b = 0; b < MASK_W; b++) begin
        if (m[b]) begin
          chk(out_valid_o && (out_item_o == ITEM_W'(g * MASK_W + b)), {tag, " R4 item"},
              out_valid_o ? int'(out_item_o) : -1, g * MASK_W + b);
          chk((out_last_o == (rem == 1)) && (drain_done_o == (rem == 1)), {tag, " R5 last/done"},
              {out_last_o, drain_done_o}, (rem == 1) ? 3 : 0);
          rem--;
          if (rem > 0) @(negedge clk);
        end
      end
    end
    @(negedge clk);
    chk(!out_valid_o && !drain_done_o, {tag, " R10 idle after done"},
        {out_valid_o, drain_done_o}, 0);
  endtask

  task automatic t_reset;
    chk(!out_valid_o && !drain_done_o && item_ready_o && drain_ready_o, "R11 reset outputs",
        {out_valid_o, drain_done_o, item_ready_o, drain_ready_o}, 3);
    for (int g = 0; g < (1 << GRP_W); g++) drain_check(g, '0, "R11 empty after reset");
  endtask

  task automatic t_example;
    int seq [11] = '{3, 8, 1, 6, 9, 13, 15, 7, 11, 10, 14};
    foreach (seq[i]) push(seq[i]);
    // R1 R3: grouping by upper bits, words with bit 0 rightmost
    drain_check(0, 4'b1010, "R3 grp0");
    drain_check(1, 4'b1100, "R3 grp1");
    drain_check(2, 4'b1111, "R3 grp2");
    drain_check(3, 4'b1110, "R1 grp3");
    drain_check(2, 4'b1111, "R12 redrain grp2");
  endtask

  task automatic t_hold_off;
    // drain group 3 (values 13,14,15); item 12 for group 3 must be refused
    @(negedge clk);
    drain_req_i = 1'b1;
    drain_grp_i = 2'd3;
    item_valid_i = 1'b1;
    item_i = 4'd12;
    #1 chk(!item_ready_o, "R9 refused in request cycle", item_ready_o, 0);
    @(negedge clk);
    drain_grp_i = 2'd0;
    #1 chk(!item_ready_o, "R9 refused during drain", item_ready_o, 0);
    chk(!drain_ready_o, "R10 drain_ready low while busy", drain_ready_o, 0);
    chk(out_valid_o && out_item_o == 4'd13, "R4 first item during hold", out_item_o, 13);
    @(negedge clk);
    drain_req_i = 1'b0;
    item_i = 4'd4;
    #1 chk(item_ready_o, "R9 other group accepted", item_ready_o, 1);
    @(negedge clk);
    item_valid_i = 1'b0;
    chk(drain_done_o && out_item_o == 4'd15, "R5 done on 15", out_item_o, 15);
    @(negedge clk);
    chk(!out_valid_o && !drain_done_o, "R10 ignored request made no output",
        {out_valid_o, drain_done_o}, 0);
    drain_check(3, 4'b1110, "R9 blocked item absent");
    drain_check(1, 4'b1101, "R9 other group written");
    drain_check(0, 4'b1010, "R10 grp0 unchanged");
  endtask

  task automatic t_clear;
    @(negedge clk);
    clear_i = 1'b1;
    item_valid_i = 1'b1;
    item_i = 4'd0;
    @(negedge clk);
    clear_i = 1'b0;
    item_valid_i = 1'b0;
    for (int g = 0; g < (1 << GRP_W); g++) drain_check(g, '0, "R8 cleared");
  endtask

  task automatic t_dupes;
    push(5); push(5); push(7); push(5);
    drain_check(1, 4'b1010, "R7 duplicates once");
    push(8);
    drain_check(2, 4'b0001, "R6 single item last");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_example();
    t_hold_off();
    t_clear();
    t_dupes();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule